// File: doc/BRIEF.md
# Backlight PWM Generator with Pre-divider

This block drives a display backlight with a pulse-width-modulated signal clocked from a fixed reference. The period is built from two programmable stages. An 8-bit pre-divider F turns the reference into a slow tick. A duty counter whose width Pn is chosen at run time advances once per tick. A full period therefore lasts F·2^Pn reference cycles. The output is high while the duty counter is below the programmed brightness level.

Software sets a mode bit, the pre-divider, the bit count and the brightness through a single write-strobe port. Every write lands in a shadow register. The generator copies the shadows into its working set only on the last reference cycle of a period, so a period is never cut short or stretched by a reconfiguration. When the mode bit is clear, the block ignores the written ratio and runs from a built-in default divider. The block also returns the largest meaningful brightness for the bit count in use, 2^Pn − 1, so software can scale its brightness values.

Top module: `backlight_pwm_gen`

## Requirements
- R1: When the working brightness level lies strictly between 0 and 2^Pn, rising edges of `pwm_o` are exactly F·2^Pn clock cycles apart.
- R2: Over any F·2^Pn consecutive cycles in steady state, `pwm_o` is high for min(level, 2^Pn)·F cycles.
- R3: A level of 0 holds `pwm_o` low without pause. A level of 2^Pn or more holds it high without pause.
- R4: A pre-divider value of 0 (written to address 1, bits 7:0) behaves exactly like a value of 1.
- R5: The bit count (written to address 2, bits 4:0) is clamped into [PN_MIN, PN_MAX]. With the defaults, that range is [2, 8].
- R6: `max_level_o` equals 2^Pn − 1, where Pn is the clamped bit count currently in use.
- R7: While the mode bit (address 0, bit 0) is 0, the generator uses DEF_F and DEF_PN (4 and 6 by default) whatever values were written for the ratio. Brightness is written to address 3 and is used in both modes.
- R8: Written values take effect only at the end of the period in progress. Until then, `max_level_o` and the waveform keep their previous settings.
- R9: A synchronous reset drives `pwm_o` low and clears both counters. It loads the default ratio with level 0, so after reset `max_level_o` is 63 under the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 2 | Register select: 0 mode, 1 pre-divider, 2 bit count, 3 level |
| wr_data | input | BRT_W | Write data |
| pwm_o | output | 1 | Backlight PWM output |
| max_level_o | output | BRT_W | Largest meaningful level for the active bit count |

## Verification
A write reaches its shadow register one edge after the strobe. It reaches `pwm_o` and `max_level_o` only at the edge that closes the current period, and `pwm_o` is registered from the counter state of that same edge. The checks therefore never sample right after a write. After each configuration, the bench waits twice the longest period that any partly written mix of old and new values could produce. It then measures duty and edge spacing over whole periods. This makes the results independent of the phase at which sampling begins. The hold-off check samples a few cycles after a period start, well before the boundary, and samples again once a full period has passed.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

    localparam int F_W  = 8;
    localparam int PN_W = 5;

    // Pull a bit count into the supported window.
    function automatic logic [PN_W-1:0] clamp_pn(input logic [PN_W-1:0] pn,
                                                 input int lo, input int hi);
        if (int'(pn) < lo) return PN_W'(lo);
        if (int'(pn) > hi) return PN_W'(hi);
        return pn;
    endfunction

    // A zero pre-divider is run as a divide-by-one.
    function automatic logic [F_W-1:0] nonzero_f(input logic [F_W-1:0] f);
        return (f == '0) ? F_W'(1) : f;
    endfunction

endpackage

// File: rtl/bl_shadow_regs.sv
module bl_shadow_regs
    import bl_pwm_pkg::*;
#(
    parameter int BRT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [BRT_W-1:0] wr_data,
    output logic             en_o,
    output logic [F_W-1:0]   f_o,
    output logic [PN_W-1:0]  pn_o,
    output logic [BRT_W-1:0] lvl_o
);

    typedef struct packed {
        logic             en;
        logic [F_W-1:0]   f;
        logic [PN_W-1:0]  pn;
        logic [BRT_W-1:0] lvl;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (wr_en) begin
            unique case (wr_addr)
                2'd0: sh_d.en  = wr_data[0];
                2'd1: sh_d.f   = wr_data[F_W-1:0];
                2'd2: sh_d.pn  = wr_data[PN_W-1:0];
                default: sh_d.lvl = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '{en: 1'b0, f: F_W'(1), pn: '0, lvl: '0};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign en_o  = sh_q.en;
    assign f_o   = sh_q.f;
    assign pn_o  = sh_q.pn;
    assign lvl_o = sh_q.lvl;

endmodule

// File: rtl/bl_ratio_sel.sv
module bl_ratio_sel
    import bl_pwm_pkg::*;
#(
    parameter int PN_MIN = 2,
    parameter int PN_MAX = 8,
    parameter int DEF_F  = 4,
    parameter int DEF_PN = 6
) (
    input  logic            en_i,
    input  logic [F_W-1:0]  f_i,
    input  logic [PN_W-1:0] pn_i,
    output logic [F_W-1:0]  f_eff_o,
    output logic [PN_W-1:0] pn_eff_o
);

    logic [F_W-1:0]  f_raw;
    logic [PN_W-1:0] pn_raw;

    always_comb begin
        f_raw    = en_i ? f_i  : F_W'(DEF_F);
        pn_raw   = en_i ? pn_i : PN_W'(DEF_PN);
        f_eff_o  = nonzero_f(f_raw);
        pn_eff_o = clamp_pn(pn_raw, PN_MIN, PN_MAX);
    end

endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
    import bl_pwm_pkg::*;
#(
    parameter int BRT_W  = 16,
    parameter int PN_MIN = 2,
    parameter int PN_MAX = 8,
    parameter int DEF_F  = 4,
    parameter int DEF_PN = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [F_W-1:0]   f_eff_i,
    input  logic [PN_W-1:0]  pn_eff_i,
    input  logic [BRT_W-1:0] lvl_i,
    output logic             pwm_o,
    output logic [PN_W-1:0]  pn_act_o
);

    localparam int CNT_W = (PN_MAX < 1) ? 1 : PN_MAX;
    localparam int SPN_W = CNT_W + 1;
    localparam logic [F_W-1:0]  RST_F  = nonzero_f(F_W'(DEF_F));
    localparam logic [PN_W-1:0] RST_PN = clamp_pn(PN_W'(DEF_PN), PN_MIN, PN_MAX);

    typedef struct packed {
        logic [F_W-1:0]   pc;
        logic [CNT_W-1:0] dc;
        logic [F_W-1:0]   f_act;
        logic [PN_W-1:0]  pn_act;
        logic [BRT_W-1:0] lvl;
        logic             pwm;
    } core_t;

    core_t st_d, st_q;
    logic  tick, wrap;

    always_comb begin
        st_d = st_q;
        tick = (st_q.pc == st_q.f_act - F_W'(1));
        wrap = ({1'b0, st_q.dc} + SPN_W'(1)) == (SPN_W'(1) << st_q.pn_act);
        if (tick) begin
            st_d.pc = '0;
            if (wrap) begin
                st_d.dc     = '0;
                st_d.f_act  = f_eff_i;
                st_d.pn_act = pn_eff_i;
                st_d.lvl    = lvl_i;
            end else begin
                st_d.dc = st_q.dc + CNT_W'(1);
            end
        end else begin
            st_d.pc = st_q.pc + F_W'(1);
        end
        st_d.pwm = BRT_W'(st_d.dc) < st_d.lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{pc: '0, dc: '0, f_act: RST_F, pn_act: RST_PN,
                      lvl: '0, pwm: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o    = st_q.pwm;
    assign pn_act_o = st_q.pn_act;

    // R1
    duty_range_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, st_q.dc} < (SPN_W'(1) << st_q.pn_act)));

    // R4
    pre_range_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.f_act != '0) && (st_q.pc < st_q.f_act));

    // R5
    pn_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(st_q.pn_act) >= PN_MIN) && (int'(st_q.pn_act) <= PN_MAX));

    // R8
    hold_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        !(tick && wrap) |=> ($stable(st_q.pn_act) && $stable(st_q.f_act)
                             && $stable(st_q.lvl)));

    // R3
    dark_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.lvl == '0) |-> !st_q.pwm);

endmodule

// File: rtl/backlight_pwm_gen.sv
module backlight_pwm_gen
    import bl_pwm_pkg::*;
#(
    parameter int BRT_W  = 16,
    parameter int PN_MIN = 2,
    parameter int PN_MAX = 8,
    parameter int DEF_F  = 4,
    parameter int DEF_PN = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [BRT_W-1:0] wr_data,
    output logic             pwm_o,
    output logic [BRT_W-1:0] max_level_o
);

    logic             sh_en;
    logic [F_W-1:0]   sh_f;
    logic [PN_W-1:0]  sh_pn;
    logic [BRT_W-1:0] sh_lvl;
    logic [F_W-1:0]   f_eff;
    logic [PN_W-1:0]  pn_eff;
    logic [PN_W-1:0]  pn_act;

    bl_shadow_regs #(.BRT_W(BRT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .en_o    (sh_en),
        .f_o     (sh_f),
        .pn_o    (sh_pn),
        .lvl_o   (sh_lvl)
    );

    bl_ratio_sel #(
        .PN_MIN (PN_MIN), .PN_MAX (PN_MAX),
        .DEF_F  (DEF_F),  .DEF_PN (DEF_PN)
    ) u_sel (
        .en_i     (sh_en),
        .f_i      (sh_f),
        .pn_i     (sh_pn),
        .f_eff_o  (f_eff),
        .pn_eff_o (pn_eff)
    );

    bl_pwm_core #(
        .BRT_W  (BRT_W),
        .PN_MIN (PN_MIN), .PN_MAX (PN_MAX),
        .DEF_F  (DEF_F),  .DEF_PN (DEF_PN)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .f_eff_i  (f_eff),
        .pn_eff_i (pn_eff),
        .lvl_i    (sh_lvl),
        .pwm_o    (pwm_o),
        .pn_act_o (pn_act)
    );

    assign max_level_o = (BRT_W'(1) << pn_act) - BRT_W'(1);

endmodule

// File: tb/tb_backlight_pwm_gen.sv
`timescale 1ns/1ps
module tb_backlight_pwm_gen;

    localparam int BRT_W  = 16;
    localparam int PN_MIN = 2;
    localparam int PN_MAX = 8;
    localparam int DEF_F  = 4;
    localparam int DEF_PN = 6;

    logic             clk = 1'b0;
    logic             rst;
    logic             wr_en;
    logic [1:0]       wr_addr;
    logic [BRT_W-1:0] wr_data;
    logic             pwm;
    logic [BRT_W-1:0] max_level;

    int n_chk  = 0;
    int n_fail = 0;

    bit c_en;
    int c_f, c_pn, c_lvl;

    always #2 clk = ~clk;

    backlight_pwm_gen #(
        .BRT_W(BRT_W), .PN_MIN(PN_MIN), .PN_MAX(PN_MAX),
        .DEF_F(DEF_F), .DEF_PN(DEF_PN)
    ) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_o(pwm), .max_level_o(max_level)
    );

    function automatic int exp_f(bit en, int f);
        int v = en ? f : DEF_F;
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int exp_pn(bit en, int pn);
        int v = en ? pn : DEF_PN;
        if (v < PN_MIN) v = PN_MIN;
        if (v > PN_MAX) v = PN_MAX;
        return v;
    endfunction

    function automatic int exp_p(bit en, int f, int pn);
        return exp_f(en, f) * (1 << exp_pn(en, pn));
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(int addr, int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 2'(addr);
        wr_data = BRT_W'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Write mode, F, Pn, level in that order; wait out every partial mix.
    task automatic configure(bit en, int f, int pn, int lvl);
        int m;
        m = exp_p(c_en, c_f, c_pn);
        m = max2(m, exp_p(en, c_f, c_pn));
        m = max2(m, exp_p(en, f, c_pn));
        m = max2(m, exp_p(en, f, pn));
        wr(0, int'(en));
        wr(1, f);
        wr(2, pn);
        wr(3, lvl);
        c_en = en; c_f = f; c_pn = pn; c_lvl = lvl;
        repeat (2 * m + 8) @(negedge clk);
    endtask

    task automatic measure(string tag);
        int p, pnx, fx, full, hi, exp_hi, gap;
        bit prev, seen;
        p    = exp_p(c_en, c_f, c_pn);
        pnx  = exp_pn(c_en, c_pn);
        fx   = exp_f(c_en, c_f);
        full = 1 << pnx;
        check($sformatf("R6 max level [%s]", tag), int'(max_level), full - 1);
        hi = 0;
        for (int i = 0; i < p; i++) begin
            @(negedge clk);
            if (pwm) hi++;
        end
        exp_hi = ((c_lvl >= full) ? full : c_lvl) * fx;
        if (c_lvl == 0 || c_lvl >= full)
            check($sformatf("R3 constant level [%s]", tag), hi, exp_hi);
        else begin
            check($sformatf("R2 high time [%s]", tag), hi, exp_hi);
            prev = pwm; seen = 1'b0;
            for (int i = 0; i < 2 * p + 2 && !seen; i++) begin
                @(negedge clk);
                if (!prev && pwm) seen = 1'b1;
                prev = pwm;
            end
            gap = 0; seen = 1'b0;
            for (int i = 0; i < 2 * p + 2 && !seen; i++) begin
                @(negedge clk);
                gap++;
                if (!prev && pwm) seen = 1'b1;
                prev = pwm;
            end
            check($sformatf("R1 period [%s]", tag), gap, p);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual %0d expected %0d", 190000, 0);
        report();
    end

    initial begin
        bit prev;
        void'($urandom(32'd5113));
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        c_en = 1'b0; c_f = 1; c_pn = 0; c_lvl = 0;
        repeat (4) @(negedge clk);
        check("R9 output low in reset", int'(pwm), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 default max level", int'(max_level), 63);
        measure("R9 after reset");

        configure(1'b1, 2, 5, 7);     measure("R1 R2 basic");
        configure(1'b1, 0, 3, 5);     measure("R4 zero divider");
        configure(1'b1, 3, 0, 1);     measure("R5 low clamp");
        configure(1'b1, 1, 31, 300);  measure("R5 high clamp full on");
        configure(1'b1, 2, 4, 0);     measure("R3 dark");
        configure(1'b0, 3, 3, 20);    measure("R7 default divider");
        configure(1'b1, 255, 2, 2);   measure("R2 widest divider");

        // R8: change Pn mid-period, old value must hold until the boundary
        configure(1'b1, 2, 6, 10);
        prev = pwm;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!prev && pwm) break;
            prev = pwm;
        end
        wr(2, 4);
        c_pn = 4;
        repeat (5) @(negedge clk);
        check("R8 hold until period end", int'(max_level), 63);
        repeat (130) @(negedge clk);
        check("R8 load at period end", int'(max_level), 15);
        measure("R8 after load");

        for (int k = 0; k < 14; k++) begin
            bit en;
            int f, pn, lvl, sel, full;
            en  = ($urandom % 5) != 0;
            f   = $urandom % 6;
            pn  = $urandom % 10;
            full = 1 << exp_pn(en, pn);
            sel = $urandom % 4;
            if (sel == 0)      lvl = 0;
            else if (sel == 1) lvl = full + ($urandom % 3);
            else               lvl = 1 + ($urandom % (full - 1));
            configure(en, f, pn, lvl);
            measure($sformatf("R2 random %0d", k));
        end
        report();
    end

endmodule